// File: doc/BRIEF.md
# ADC Conversion Autosequencer

This block runs a series of conversions on an external 10-bit converter so that a host never has to step through channels one by one. It holds sixteen sequence states, each with a programmable 4-bit channel number. When a trigger arrives, a sequencer walks through a programmed number of states. For each state it puts the channel on the converter mux, pulses a start and waits for the converter's done pulse. It then writes the converted value into the result register that has the same index as the state. A register bus sets the channel table, the mode and the group lengths, issues soft resets and reads back the results.

One mode bit chooses the arrangement. The block runs either as a single cascaded sequencer over states 0 to 15, or as two independent sequencers: the first owns states 0 to 7 and channels 0 to 7, the second owns states 8 to 15 and channels 8 to 15. The two independent sequencers share the converter, and the first one wins when both ask for it at once. In continuous mode every trigger starts again at the first state. In start/stop mode each trigger converts one group of states and the pointer stays where the group ended, so that later triggers carry on through the table. Each sequencer raises an interrupt pulse after each group or after every second group. A trigger that arrives while a sequencer is busy is held as pending. A further trigger while one is already pending sets a sticky overflow flag.

Top module: `adc_autoseq`

## Requirements
- R1: After reset, all channel entries, the mode register, the length register and all result registers read 0, and `conv_start_o`, `irq_o` and `ovf_o` are 0. The block starts in dual mode.
- R2: In cascade mode (mode register 0x10 bit 0 = 1), one trigger runs L+1 conversions, where L is the length register 0x11 bits [3:0]. The conversions cover states 0..L in order. State n drives the channel held at address 0x00+n (bits [3:0]), and its converted value is stored in the result register at address 0x20+n (bits [9:0]).
- R3: In start/stop mode, the pointer steps from the last state of the sequencer's range back to the first state of that range. The range is 0..15 in cascade mode, 0..7 for sequencer 1 in dual mode and 8..15 for sequencer 2.
- R4: Any channel may be given to any number of states, and a channel that repeats is converted once for each state that names it.
- R5: `trig_i` bits are: bit 0 software start, bit 1 event source A, bit 2 event source B, bit 3 external start. In cascade mode any bit starts the sequencer. In dual mode bits 0, 1 and 3 start only sequencer 1 and bit 2 starts only sequencer 2.
- R6: In dual mode, sequencer 1 runs L1+1 states from state 0, where L1 is 0x11 bits [2:0]. Sequencer 2 runs L2+1 states from state 8, where L2 is 0x11 bits [6:4]. The channel driven is {state bit 3, entry bits [2:0]}, so each sequencer reaches only its own eight channels.
- R7: At the end of each group the sequencer raises a one-cycle pulse on its `irq_o` bit. When its every-second bit is set (0x10 bit 2 for sequencer 1, bit 3 for sequencer 2), it pulses only at every second group end counted since the last soft reset.
- R8: In continuous mode (0x10 bit 1 = 0), every trigger starts at the first state of the range. In start/stop mode (bit 1 = 1), each trigger converts one group and the block then halts with no further conversions. The next trigger carries on from the state after the last one converted.
- R9: A trigger that arrives while its sequencer is busy is held and runs as a new group once the current group ends. A further trigger while one is already held is dropped and sets that sequencer's sticky `ovf_o` bit.
- R10: In dual mode, when both sequencers request the converter in the same cycle, sequencer 1 is granted. Sequencer 2 waits until no request from sequencer 1 is outstanding.
- R11: Writing 1 to bit 0 (sequencer 1) or bit 1 (sequencer 2) of the command address 0x12 returns that sequencer's pointer to its first state. The write also clears its pending trigger, its overflow flag and its every-second phase.
- R12: Register readback returns only the implemented bits: channel entries as 4 bits, the mode register as 4 bits and the length register as 8 bits, with the upper bits reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational on address) |
| trig_i | input | 4 | Trigger pulses: software, event A, event B, external |
| conv_start_o | output | 1 | One-cycle conversion start pulse |
| conv_chan_o | output | 4 | Channel for the current conversion |
| conv_done_i | input | 1 | One-cycle conversion done pulse |
| conv_data_i | input | 10 | Converted value, valid with conv_done_i |
| irq_o | output | 2 | End-of-group interrupt pulse per sequencer |
| ovf_o | output | 2 | Sticky trigger overflow flag per sequencer |

## Verification
The hardest situation to reach from the ports is contention on the converter: both sequencers requesting in one cycle, and a trigger arriving while a group is in progress and another is already held. The bench reaches it by pulsing event A and event B in the same cycle. It also pulses event A again two and four cycles after a group has started, while a converter model with a fixed three-cycle latency keeps the sequencer busy. The bench then checks the logged order of channels and the overflow flag. Start/stop wrap-around is reached by six triggers of three states each, so the pointer passes state 15 and returns to 0.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_REQ  = 2'd1,
    SQ_WAIT = 2'd2
  } sq_state_e;

  localparam logic [5:0] ADDR_MODE = 6'h10;
  localparam logic [5:0] ADDR_LEN  = 6'h11;
  localparam logic [5:0] ADDR_CMD  = 6'h12;
  localparam logic [1:0] PAGE_CHAN = 2'b00;
  localparam logic [1:0] PAGE_RES  = 2'b10;
endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned IDX_W = 4,
  parameter logic [IDX_W-1:0] BASE = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             trig_i,
  input  logic             sreset_i,
  input  logic             ss_mode_i,
  input  logic             alt_irq_i,
  input  logic [IDX_W-1:0] limit_i,
  input  logic [IDX_W-1:0] len_i,
  input  logic             gnt_i,
  input  logic             done_i,
  output logic             req_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             irq_o,
  output logic             ovf_o
);
  sq_state_e        state_q;
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] cnt_q;
  logic             pend_q;
  logic             ovf_q;
  logic             tog_q;
  logic             irq_q;
  logic             last_w;

  assign last_w = (cnt_q == len_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      ptr_q   <= BASE;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      ovf_q   <= 1'b0;
      tog_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else if (sreset_i) begin
      state_q <= SQ_IDLE;
      ptr_q   <= BASE;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      ovf_q   <= 1'b0;
      tog_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      case (state_q)
        SQ_IDLE: begin
          if (en_i && (trig_i || pend_q)) begin
            state_q <= SQ_REQ;
            pend_q  <= 1'b0;
            cnt_q   <= '0;
            if (!ss_mode_i) ptr_q <= BASE;
          end
        end
        SQ_REQ: begin
          if (gnt_i) state_q <= SQ_WAIT;
        end
        SQ_WAIT: begin
          if (done_i) begin
            ptr_q <= (ptr_q == limit_i) ? BASE : ptr_q + 1'b1;
            cnt_q <= cnt_q + 1'b1;
            if (last_w) begin
              state_q <= SQ_IDLE;
              tog_q   <= ~tog_q;
              irq_q   <= !alt_irq_i || tog_q;
            end else begin
              state_q <= SQ_REQ;
            end
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
      // trigger while busy: hold one, flag the next
      if (en_i && trig_i && (state_q != SQ_IDLE)) begin
        if (pend_q) ovf_q <= 1'b1;
        else        pend_q <= 1'b1;
      end
    end
  end

  assign req_o = (state_q == SQ_REQ);
  assign idx_o = ptr_q;
  assign irq_o = irq_q;
  assign ovf_o = ovf_q;

  assert_irq_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  assert_ovf_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !sreset_i) |=> ovf_o);

  assert_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !gnt_i && !sreset_i) |=> req_o);
endmodule

// File: rtl/adc_conv_arb.sv
module adc_conv_arb #(
  parameter int unsigned IDX_W = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [1:0]            req_i,
  input  logic [1:0][IDX_W-1:0] idx_i,
  input  logic [1:0][IDX_W-1:0] chan_i,
  input  logic                  conv_done_i,
  output logic [1:0]            gnt_o,
  output logic [1:0]            done_o,
  output logic                  conv_start_o,
  output logic [IDX_W-1:0]      conv_chan_o,
  output logic                  wr_en_o,
  output logic [IDX_W-1:0]      wr_idx_o,
  output logic                  owner_o
);
  logic             busy_q;
  logic             start_q;
  logic             owner_q;
  logic [IDX_W-1:0] chan_q;
  logic [IDX_W-1:0] idx_q;
  logic             pick_w;

  assign pick_w   = !req_i[0];
  assign gnt_o[0] = !busy_q && req_i[0];
  assign gnt_o[1] = !busy_q && req_i[1] && !req_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      owner_q <= 1'b0;
      chan_q  <= '0;
      idx_q   <= '0;
    end else begin
      start_q <= 1'b0;
      if (!busy_q && |req_i) begin
        busy_q  <= 1'b1;
        start_q <= 1'b1;
        owner_q <= pick_w;
        chan_q  <= chan_i[pick_w];
        idx_q   <= idx_i[pick_w];
      end else if (busy_q && conv_done_i) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign done_o[0]    = busy_q && conv_done_i && !owner_q;
  assign done_o[1]    = busy_q && conv_done_i && owner_q;
  assign conv_start_o = start_q;
  assign conv_chan_o  = chan_q;
  assign wr_en_o      = busy_q && conv_done_i;
  assign wr_idx_o     = idx_q;
  assign owner_o      = owner_q;

  assert_start_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);

  assert_prio_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((req_i == 2'b11) && !busy_q) |=> (conv_start_o && !owner_o));
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 10,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 mem_q[i] <= '0;
      else if (we_i && (widx_i == IDX_W'(i)))      mem_q[i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[ridx_i];
endmodule

// File: rtl/adc_autoseq.sv
module adc_autoseq
  import adc_seq_pkg::*;
#(
  parameter int unsigned NUM_STATES = 16,
  parameter int unsigned DATA_W     = 10,
  parameter int unsigned REG_W      = 16,
  parameter int unsigned ADDR_W     = 6
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          reg_we_i,
  input  logic [ADDR_W-1:0]             reg_addr_i,
  input  logic [REG_W-1:0]              reg_wdata_i,
  output logic [REG_W-1:0]              reg_rdata_o,
  input  logic [3:0]                    trig_i,
  output logic                          conv_start_o,
  output logic [$clog2(NUM_STATES)-1:0] conv_chan_o,
  input  logic                          conv_done_i,
  input  logic [DATA_W-1:0]             conv_data_i,
  output logic [1:0]                    irq_o,
  output logic [1:0]                    ovf_o
);
  localparam int unsigned IDX_W = $clog2(NUM_STATES);
  localparam int unsigned HALF  = NUM_STATES / 2;

  logic [IDX_W-1:0]   chan_q [NUM_STATES];
  logic               casc_q;
  logic               ss_q;
  logic [1:0]         alt_q;
  logic [2*IDX_W-1:0] len_q;
  logic               wr_chan_w;
  logic [1:0]         sreset_w;
  logic               unused_wdata;

  assign wr_chan_w    = reg_we_i && (reg_addr_i[ADDR_W-1:IDX_W] == PAGE_CHAN);
  assign sreset_w     = (reg_we_i && reg_addr_i == ADDR_CMD) ? reg_wdata_i[1:0] : 2'b00;
  assign unused_wdata = ^reg_wdata_i[REG_W-1:2*IDX_W];

  for (genvar i = 0; i < NUM_STATES; i++) begin : g_chan
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chan_q[i] <= '0;
      else if (wr_chan_w && reg_addr_i[IDX_W-1:0] == IDX_W'(i))
        chan_q[i] <= reg_wdata_i[IDX_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      casc_q <= 1'b0;
      ss_q   <= 1'b0;
      alt_q  <= 2'b00;
      len_q  <= '0;
    end else if (reg_we_i) begin
      if (reg_addr_i == ADDR_MODE) begin
        casc_q <= reg_wdata_i[0];
        ss_q   <= reg_wdata_i[1];
        alt_q  <= reg_wdata_i[3:2];
      end
      if (reg_addr_i == ADDR_LEN) len_q <= reg_wdata_i[2*IDX_W-1:0];
    end
  end

  // trigger routing
  logic [1:0] seq_trig;
  logic [1:0] seq_en;
  assign seq_trig[0] = casc_q ? |trig_i : (trig_i[0] | trig_i[1] | trig_i[3]);
  assign seq_trig[1] = trig_i[2];
  assign seq_en      = {~casc_q, 1'b1};

  logic [1:0]            seq_req;
  logic [1:0]            seq_gnt;
  logic [1:0]            seq_done;
  logic [1:0][IDX_W-1:0] seq_idx;
  logic [1:0][IDX_W-1:0] seq_chan;
  logic                  res_we;
  logic [IDX_W-1:0]      res_widx;
  logic                  arb_owner;

  for (genvar g = 0; g < 2; g++) begin : g_seq
    localparam logic [IDX_W-1:0] BASE = IDX_W'(g * HALF);
    logic [IDX_W-1:0] limit_w;
    logic [IDX_W-1:0] len_w;
    logic [IDX_W-1:0] ent_w;

    if (g == 0) begin : g_first
      assign limit_w = casc_q ? IDX_W'(NUM_STATES - 1) : IDX_W'(HALF - 1);
      assign len_w   = casc_q ? len_q[IDX_W-1:0] : {1'b0, len_q[IDX_W-2:0]};
    end else begin : g_second
      assign limit_w = IDX_W'(NUM_STATES - 1);
      assign len_w   = {1'b0, len_q[IDX_W +: IDX_W-1]};
    end

    assign ent_w       = chan_q[seq_idx[g]];
    // dual mode: upper channel bit follows the sequencer's own half
    assign seq_chan[g] = casc_q ? ent_w : {seq_idx[g][IDX_W-1], ent_w[IDX_W-2:0]};

    adc_seq_ctrl #(
      .IDX_W(IDX_W),
      .BASE (BASE)
    ) u_seq (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (seq_en[g]),
      .trig_i   (seq_trig[g]),
      .sreset_i (sreset_w[g]),
      .ss_mode_i(ss_q),
      .alt_irq_i(alt_q[g]),
      .limit_i  (limit_w),
      .len_i    (len_w),
      .gnt_i    (seq_gnt[g]),
      .done_i   (seq_done[g]),
      .req_o    (seq_req[g]),
      .idx_o    (seq_idx[g]),
      .irq_o    (irq_o[g]),
      .ovf_o    (ovf_o[g])
    );
  end

  adc_conv_arb #(
    .IDX_W(IDX_W)
  ) u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (seq_req),
    .idx_i       (seq_idx),
    .chan_i      (seq_chan),
    .conv_done_i (conv_done_i),
    .gnt_o       (seq_gnt),
    .done_o      (seq_done),
    .conv_start_o(conv_start_o),
    .conv_chan_o (conv_chan_o),
    .wr_en_o     (res_we),
    .wr_idx_o    (res_widx),
    .owner_o     (arb_owner)
  );

  logic [DATA_W-1:0] res_rdata;

  adc_result_bank #(
    .DEPTH (NUM_STATES),
    .DATA_W(DATA_W)
  ) u_res (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (res_we),
    .widx_i (res_widx),
    .wdata_i(conv_data_i),
    .ridx_i (reg_addr_i[IDX_W-1:0]),
    .rdata_o(res_rdata)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i[ADDR_W-1:IDX_W] == PAGE_CHAN)
      reg_rdata_o = {{(REG_W-IDX_W){1'b0}}, chan_q[reg_addr_i[IDX_W-1:0]]};
    else if (reg_addr_i[ADDR_W-1:IDX_W] == PAGE_RES)
      reg_rdata_o = {{(REG_W-DATA_W){1'b0}}, res_rdata};
    else if (reg_addr_i == ADDR_MODE)
      reg_rdata_o = {{(REG_W-4){1'b0}}, alt_q, ss_q, casc_q};
    else if (reg_addr_i == ADDR_LEN)
      reg_rdata_o = {{(REG_W-2*IDX_W){1'b0}}, len_q};
  end

  assert_dual_chan_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_start_o && !casc_q) |-> (conv_chan_o[IDX_W-1] == arb_owner));
endmodule

// File: tb/adc_autoseq_bench.sv
module adc_autoseq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [3:0]  trig_in = '0;
  logic        conv_start;
  logic [3:0]  conv_chan;
  logic        conv_done = 1'b0;
  logic [9:0]  conv_data = '0;
  logic [1:0]  irq;
  logic [1:0]  ovf;

  always #5 clk = ~clk;

  adc_autoseq u_adc_autoseq (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .trig_i(trig_in),
    .conv_start_o(conv_start), .conv_chan_o(conv_chan), .conv_done_i(conv_done),
    .conv_data_i(conv_data), .irq_o(irq), .ovf_o(ovf)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [3:0] log_chan [1024];
  logic [9:0] log_data [1024];
  int n_start = 0;
  int n_done = 0;
  int mcnt = 0;
  logic [3:0] m_chan = '0;
  int irq_n0 = 0;
  int irq_n1 = 0;
  logic [3:0] chan_sh [16];
  logic [9:0] exp_res [16];
  int walk_ptr = 0;

  // converter model: done three cycles after start
  always @(negedge clk) begin
    conv_done = 1'b0;
    if (mcnt > 0) begin
      mcnt--;
      if (mcnt == 0) begin
        conv_data = {m_chan, n_done[5:0]};
        log_data[n_done] = conv_data;
        n_done++;
        conv_done = 1'b1;
      end
    end
    if (conv_start) begin
      m_chan = conv_chan;
      log_chan[n_start] = conv_chan;
      n_start++;
      mcnt = 3;
    end
    irq_n0 += int'(irq[0]);
    irq_n1 += int'(irq[1]);
  end

  task automatic check(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input logic [3:0] t);
    @(negedge clk);
    trig_in = t;
    @(negedge clk);
    trig_in = '0;
  endtask

  task automatic settle();
    repeat (160) @(negedge clk);
  endtask

  task automatic prog_chans(input int seed, input bit same);
    for (int n = 0; n < 16; n++) begin
      chan_sh[n] = same ? 4'd9 : 4'((n * 7 + seed) & 15);
      wr(6'(n), {12'h0, chan_sh[n]});
    end
  endtask

  function automatic logic [3:0] exp_chan(input int st, input bit casc);
    logic [3:0] s4;
    s4 = st[3:0];
    return casc ? chan_sh[s4] : {s4[3], chan_sh[s4][2:0]};
  endfunction

  task automatic walk(input string rq, input int first, input int st0, input int cnt,
                      input bit casc, input int base, input int lim);
    int st;
    st = st0;
    for (int k = 0; k < cnt; k++) begin
      check(rq, int'(log_chan[first + k]), int'(exp_chan(st, casc)));
      exp_res[st] = log_data[first + k];
      st = (st == lim) ? base : st + 1;
    end
    walk_ptr = st;
  endtask

  task automatic chk_results(input string rq);
    logic [15:0] d;
    for (int n = 0; n < 16; n++) begin
      rd(6'h20 + 6'(n), d);
      check(rq, int'(d), int'(exp_res[n]));
    end
  endtask

  initial begin
    logic [15:0] d;
    int s, i0, i1;
    for (int n = 0; n < 16; n++) exp_res[n] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 start", int'(conv_start), 0);
    check("R1 irq", int'(irq), 0);
    check("R1 ovf", int'(ovf), 0);
    rd(6'h10, d); check("R1 mode", int'(d), 0);
    rd(6'h11, d); check("R1 len", int'(d), 0);
    rd(6'h03, d); check("R1 chan", int'(d), 0);
    chk_results("R1 results");

    // R12: readback widths
    wr(6'h05, 16'hFFFF); rd(6'h05, d); check("R12 chan", int'(d), 15);
    wr(6'h11, 16'h12AB); rd(6'h11, d); check("R12 len", int'(d), 'hAB);
    wr(6'h10, 16'hFFF6); rd(6'h10, d); check("R12 mode", int'(d), 6);

    // R2/R4/R5/R7: cascade continuous sweep over every length
    wr(6'h10, 16'h0001);
    for (int len = 0; len < 16; len++) begin
      prog_chans(len + 1, len == 5);
      wr(6'h11, 16'(len));
      s = n_start; i0 = irq_n0;
      pulse(4'(1 << (len % 4)));
      settle();
      check("R5 cascade trigger count", n_start - s, len + 1);
      walk(len == 5 ? "R4 repeat chan" : "R2 chan", s, 0, len + 1, 1'b1, 0, 15);
      check("R7 irq every", irq_n0 - i0, 1);
      chk_results("R2 results");
    end

    // R8: continuous restarts at state 0
    wr(6'h11, 16'd3);
    s = n_start; pulse(4'b0001); settle(); pulse(4'b0001); settle();
    check("R8 cont count", n_start - s, 8);
    walk("R8 cont first", s, 0, 4, 1'b1, 0, 15);
    walk("R8 cont restart", s + 4, 0, 4, 1'b1, 0, 15);

    // R3/R8: start/stop groups wrapping past the last state
    wr(6'h10, 16'h0003); wr(6'h12, 16'h0001); wr(6'h11, 16'd2);
    prog_chans(11, 1'b0);
    walk_ptr = 0;
    for (int g = 0; g < 6; g++) begin
      s = n_start; pulse(4'b0010); settle();
      check("R8 group size", n_start - s, 3);
      walk("R3 wrap", s, walk_ptr, 3, 1'b1, 0, 15);
    end
    s = n_start; settle();
    check("R8 halted", n_start - s, 0);
    chk_results("R3 results");

    // R11: soft reset returns pointer to state 0
    wr(6'h12, 16'h0001); wr(6'h11, 16'd1);
    s = n_start; pulse(4'b0001); settle();
    wr(6'h12, 16'h0001);
    pulse(4'b0001); settle();
    check("R11 count", n_start - s, 4);
    walk("R11 first", s, 0, 2, 1'b1, 0, 15);
    walk("R11 after reset", s + 2, 0, 2, 1'b1, 0, 15);

    // R7: interrupt at every second group
    wr(6'h10, 16'h0005); wr(6'h12, 16'h0001); wr(6'h11, 16'd0);
    i0 = irq_n0; pulse(4'b0001); settle();
    check("R7 alt first", irq_n0 - i0, 0);
    pulse(4'b0001); settle();
    check("R7 alt second", irq_n0 - i0, 1);
    pulse(4'b0001); settle(); pulse(4'b0001); settle();
    check("R7 alt fourth", irq_n0 - i0, 2);

    // R5/R6: dual mode routing and channel restriction
    wr(6'h10, 16'h0000); wr(6'h12, 16'h0003); wr(6'h11, 16'h0032);
    prog_chans(13, 1'b0);
    s = n_start; i0 = irq_n0; i1 = irq_n1;
    pulse(4'b0100); settle();
    check("R5 B count", n_start - s, 4);
    walk("R6 seq2 chan", s, 8, 4, 1'b0, 8, 15);
    check("R5 B irq2", irq_n1 - i1, 1);
    check("R5 B no irq1", irq_n0 - i0, 0);
    for (int t = 0; t < 3; t++) begin
      s = n_start; i0 = irq_n0; i1 = irq_n1;
      pulse(t == 0 ? 4'b0010 : (t == 1 ? 4'b1000 : 4'b0001));
      settle();
      check("R5 seq1 count", n_start - s, 3);
      walk("R6 seq1 chan", s, 0, 3, 1'b0, 0, 7);
      check("R5 seq1 irq1", irq_n0 - i0, 1);
      check("R5 seq1 no irq2", irq_n1 - i1, 0);
    end
    chk_results("R6 results");

    // R10: simultaneous triggers, sequencer 1 first
    s = n_start;
    pulse(4'b0110); settle();
    check("R10 count", n_start - s, 7);
    walk("R10 seq1 first", s, 0, 3, 1'b0, 0, 7);
    walk("R10 seq2 after", s + 3, 8, 4, 1'b0, 8, 15);

    // R9: pending and overflow
    s = n_start;
    pulse(4'b0010); repeat (2) @(negedge clk); pulse(4'b0010); settle();
    check("R9 pending count", n_start - s, 6);
    walk("R9 pending first", s, 0, 3, 1'b0, 0, 7);
    walk("R9 pending second", s + 3, 0, 3, 1'b0, 0, 7);
    check("R9 no ovf", int'(ovf), 0);
    s = n_start;
    pulse(4'b0010); repeat (2) @(negedge clk);
    pulse(4'b0010); repeat (2) @(negedge clk);
    pulse(4'b0010); settle();
    check("R9 ovf count", n_start - s, 6);
    check("R9 ovf flag", int'(ovf), 1);
    wr(6'h12, 16'h0001);
    @(negedge clk);
    check("R11 ovf cleared", int'(ovf), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule